// File: doc/BRIEF.md
# Byte-Wide Memory-Mapped GPIO Port

This block is one eight-pin general-purpose I/O port that a processor reaches through a small register bus. Software sets which pins drive and which listen. It writes the value that driving pins present. It hands chosen pins to an on-chip peripheral, and it switches on a weak pull resistor on pins that are not driven. Reading the level register returns the pin levels after a two-flop synchronizer.

Bus accesses take one cycle. A write updates its register at the clock edge where it is presented. A read returns its data on `bus_rdata` during the cycle after the edge that accepted it. `bus_rdata` is zero in every other cycle. Only byte-sized accesses are honoured.

Top module: `pio_byte_port`

## Requirements
- R1: After reset the drive, direction, function-select and pull-enable registers are all zero. So every pin is an undriven input with no pull, and `pad_oe`, `pad_out`, `pull_en` and `pull_up` are all zero.
- R2: In GPIO mode (function-select bit 0), the direction bit sets `pad_oe` for that pin: 0 means input (not driven) and 1 means output (driven).
- R3: In GPIO mode, `pad_out` carries the drive-register bit only on pins whose direction bit is 1. On input pins `pad_out` is 0 whatever the drive register holds.
- R4: A read of the level register (offset 0x0) returns `pin_in` as sampled two clock edges before the edge that accepts the read. A change on `pin_in` is therefore not visible to a read accepted at the next edge.
- R5: When a pin's function-select bit is 1, `pad_out` and `pad_oe` follow `alt_out` and `alt_oe` for that pin, and the drive and direction registers have no effect on it.
- R6: `pull_en` is 1 on a pin whose pull-enable bit is 1 and whose `pad_oe` is 0. In that case `pull_up` equals the pin's drive-register bit (1 = pull up, 0 = pull down). Both are 0 on a pin that is driven.
- R7: `bus_size` encodes 0 = byte, 1 = halfword, 2 = word. Any non-byte write leaves every register unchanged, and any non-byte read returns zero.
- R8: Reads at offsets other than 0x0 to 0x4 return zero. Writes to the level register (offset 0x0) have no effect.
- R9: Byte reads at offsets 0x1 (drive), 0x2 (direction), 0x3 (function select) and 0x4 (pull enable) return the last value written there, one cycle after the read is accepted.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Access strobe for this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_size | input | 2 | Access size: 0 byte, 1 halfword, 2 word |
| bus_addr | input | 4 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, valid the cycle after a read is accepted |
| pin_in | input | 8 | Asynchronous pin levels |
| alt_out | input | 8 | Peripheral output value per pin |
| alt_oe | input | 8 | Peripheral output enable per pin |
| pad_out | output | 8 | Value to drive on each pin |
| pad_oe | output | 8 | Drive enable for each pin |
| pull_en | output | 8 | Weak pull resistor enable per pin |
| pull_up | output | 8 | Pull direction: 1 up, 0 down |

## Verification
The following rules are checked by assertions on every clock:
- Pins handed to the peripheral mirror `alt_out`/`alt_oe`.
- Undriven GPIO inputs present zero.
- No pull is ever on while a pin drives.
- Mis-sized or unmapped reads return zero.
- Mis-sized writes and level-register writes leave the registers unchanged.
- A level read matches the pin value from three edges earlier.

Only the bench scenarios can show the remaining behaviour:
- The reset state.
- The exact mix of driven and undriven pins across the direction, select and pull combinations.
- Pull direction taken from the drive register.
- Readback of each stored register.
- That a freshly changed pin is still invisible to an immediate read.

// File: rtl/pio_pkg.sv
package pio_pkg;

  localparam int unsigned OFS_LEVEL = 0;
  localparam int unsigned OFS_DRIVE = 1;
  localparam int unsigned OFS_DIR   = 2;
  localparam int unsigned OFS_FSEL  = 3;
  localparam int unsigned OFS_PULL  = 4;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2
  } acc_size_e;

  // Pin drive enable: peripheral wins when selected.
  function automatic logic pin_oe(input logic fsel, input logic dir, input logic a_oe);
    return fsel ? a_oe : dir;
  endfunction

  // Pin output value: GPIO value only reaches the pad on output pins.
  function automatic logic pin_val(input logic fsel, input logic dir, input logic drv,
                                   input logic a_out);
    return fsel ? a_out : (dir & drv);
  endfunction

  // Pull is only applied on a pin that is not being driven.
  function automatic logic pull_on(input logic pen, input logic oe);
    return pen & ~oe;
  endfunction

  // Pull direction comes from the drive bit while the pull is on.
  function automatic logic pull_dir(input logic pen, input logic oe, input logic drv);
    return pen & ~oe & drv;
  endfunction

endpackage

// File: rtl/pio_sync.sv
module pio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o,
  output logic             warm_o
);

  localparam int unsigned CNT_W   = $clog2(STAGES + 1) + 1;
  localparam int unsigned WARM_AT = STAGES;

  logic [WIDTH-1:0] stg [STAGES];
  logic [CNT_W-1:0] warm_cnt;

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    if (s == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= async_i;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stg[s] <= '0;
        else        stg[s] <= stg[s-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                         warm_cnt <= '0;
    else if (warm_cnt < CNT_W'(WARM_AT)) warm_cnt <= warm_cnt + 1'b1;
  end

  assign sync_o = stg[STAGES-1];
  assign warm_o = (warm_cnt >= CNT_W'(WARM_AT));

endmodule

// File: rtl/pio_regs.sv
module pio_regs
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  input  logic [WIDTH-1:0]  level_i,
  output logic [WIDTH-1:0]  drive_o,
  output logic [WIDTH-1:0]  dir_o,
  output logic [WIDTH-1:0]  fsel_o,
  output logic [WIDTH-1:0]  pull_o,
  output logic [WIDTH-1:0]  rdata_o
);

  localparam logic [ADDR_W-1:0] A_LEVEL = ADDR_W'(OFS_LEVEL);
  localparam logic [ADDR_W-1:0] A_DRIVE = ADDR_W'(OFS_DRIVE);
  localparam logic [ADDR_W-1:0] A_DIR   = ADDR_W'(OFS_DIR);
  localparam logic [ADDR_W-1:0] A_FSEL  = ADDR_W'(OFS_FSEL);
  localparam logic [ADDR_W-1:0] A_PULL  = ADDR_W'(OFS_PULL);

  logic [WIDTH-1:0] drive_q, dir_q, fsel_q, pull_q, rdata_q;
  logic [WIDTH-1:0] rd_mux;
  logic             size_ok, wr_fire, rd_fire, addr_mapped;

  assign size_ok     = (bus_size == SZ_BYTE);
  assign wr_fire     = bus_sel & bus_wr & size_ok;
  assign rd_fire     = bus_sel & ~bus_wr & size_ok;
  assign addr_mapped = (bus_addr == A_LEVEL) | (bus_addr == A_DRIVE) |
                       (bus_addr == A_DIR)   | (bus_addr == A_FSEL)  |
                       (bus_addr == A_PULL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      drive_q <= '0;
      dir_q   <= '0;
      fsel_q  <= '0;
      pull_q  <= '0;
    end else if (wr_fire) begin
      unique case (bus_addr)
        A_DRIVE: drive_q <= bus_wdata;
        A_DIR:   dir_q   <= bus_wdata;
        A_FSEL:  fsel_q  <= bus_wdata;
        A_PULL:  pull_q  <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    unique case (bus_addr)
      A_LEVEL: rd_mux = level_i;
      A_DRIVE: rd_mux = drive_q;
      A_DIR:   rd_mux = dir_q;
      A_FSEL:  rd_mux = fsel_q;
      A_PULL:  rd_mux = pull_q;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       rdata_q <= '0;
    else if (rd_fire) rdata_q <= rd_mux;
    else              rdata_q <= '0;
  end

  assign drive_o = drive_q;
  assign dir_o   = dir_q;
  assign fsel_o  = fsel_q;
  assign pull_o  = pull_q;
  assign rdata_o = rdata_q;

  a_r7_size_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && bus_wr && !size_ok) |=>
      ($stable(drive_q) && $stable(dir_q) && $stable(fsel_q) && $stable(pull_q)));

  a_r7_size_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !size_ok) |=> (rdata_o == '0));

  a_r8_unmapped_read_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr && !addr_mapped) |=> (rdata_o == '0));

  a_r8_level_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_fire && bus_addr == A_LEVEL) |=>
      ($stable(drive_q) && $stable(dir_q) && $stable(fsel_q) && $stable(pull_q)));

  a_r9_dir_readback: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_fire && bus_addr == A_DIR) |=> (rdata_o == $past(dir_q)));

endmodule

// File: rtl/pio_pinmux.sv
module pio_pinmux
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] drive_i,
  input  logic [WIDTH-1:0] dir_i,
  input  logic [WIDTH-1:0] fsel_i,
  input  logic [WIDTH-1:0] pull_i,
  input  logic [WIDTH-1:0] alt_out,
  input  logic [WIDTH-1:0] alt_oe,
  output logic [WIDTH-1:0] pad_out,
  output logic [WIDTH-1:0] pad_oe,
  output logic [WIDTH-1:0] pull_en,
  output logic [WIDTH-1:0] pull_up
);

  for (genvar i = 0; i < WIDTH; i++) begin : g_pin
    assign pad_oe[i]  = pin_oe(fsel_i[i], dir_i[i], alt_oe[i]);
    assign pad_out[i] = pin_val(fsel_i[i], dir_i[i], drive_i[i], alt_out[i]);
    assign pull_en[i] = pull_on(pull_i[i], pad_oe[i]);
    assign pull_up[i] = pull_dir(pull_i[i], pad_oe[i], drive_i[i]);

    a_r5_alt_route: assert property (@(posedge clk) disable iff (!rst_n)
      fsel_i[i] |-> (pad_oe[i] == alt_oe[i] && pad_out[i] == alt_out[i]));

    a_r3_input_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (!fsel_i[i] && !dir_i[i]) |-> (!pad_out[i] && !pad_oe[i]));

    a_r6_no_pull_while_driving: assert property (@(posedge clk) disable iff (!rst_n)
      pad_oe[i] |-> (!pull_en[i] && !pull_up[i]));
  end

endmodule

// File: rtl/pio_byte_port.sv
module pio_byte_port
  import pio_pkg::*;
#(
  parameter int unsigned WIDTH       = 8,
  parameter int unsigned ADDR_W      = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_size,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [WIDTH-1:0]  bus_wdata,
  output logic [WIDTH-1:0]  bus_rdata,
  input  logic [WIDTH-1:0]  pin_in,
  input  logic [WIDTH-1:0]  alt_out,
  input  logic [WIDTH-1:0]  alt_oe,
  output logic [WIDTH-1:0]  pad_out,
  output logic [WIDTH-1:0]  pad_oe,
  output logic [WIDTH-1:0]  pull_en,
  output logic [WIDTH-1:0]  pull_up
);

  logic [WIDTH-1:0] level_sync;
  logic             sync_warm;
  logic [WIDTH-1:0] drive_r, dir_r, fsel_r, pull_r;

  pio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (level_sync),
    .warm_o  (sync_warm)
  );

  pio_regs #(.WIDTH(WIDTH), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_size  (bus_size),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .level_i   (level_sync),
    .drive_o   (drive_r),
    .dir_o     (dir_r),
    .fsel_o    (fsel_r),
    .pull_o    (pull_r),
    .rdata_o   (bus_rdata)
  );

  pio_pinmux #(.WIDTH(WIDTH)) u_pinmux (
    .clk     (clk),
    .rst_n   (rst_n),
    .drive_i (drive_r),
    .dir_i   (dir_r),
    .fsel_i  (fsel_r),
    .pull_i  (pull_r),
    .alt_out (alt_out),
    .alt_oe  (alt_oe),
    .pad_out (pad_out),
    .pad_oe  (pad_oe),
    .pull_en (pull_en),
    .pull_up (pull_up)
  );

  if (SYNC_STAGES == 2) begin : g_lat_chk
    a_r4_level_latency: assert property (@(posedge clk) disable iff (!rst_n)
      (sync_warm && bus_sel && !bus_wr && bus_size == SZ_BYTE &&
       bus_addr == ADDR_W'(OFS_LEVEL)) |=> (bus_rdata == $past(pin_in, 3)));
  end

endmodule

// File: tb/pio_byte_port_bench.sv
module pio_byte_port_bench;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bus_sel = 1'b0, bus_wr = 1'b0;
  logic [1:0] bus_size = 2'd0;
  logic [3:0] bus_addr = 4'd0;
  logic [7:0] bus_wdata = 8'd0, pin_in = 8'd0, alt_out = 8'd0, alt_oe = 8'd0;
  logic [7:0] bus_rdata, pad_out, pad_oe, pull_en, pull_up;

  int n_cmp = 0, n_bad = 0;

  always #10 clk = ~clk;

  pio_byte_port u_pio_byte_port (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_size(bus_size), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .pin_in(pin_in), .alt_out(alt_out), .alt_oe(alt_oe),
    .pad_out(pad_out), .pad_oe(pad_oe), .pull_en(pull_en), .pull_up(pull_up)
  );

  task automatic chk(input string tag, input logic [7:0] got, input logic [7:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %02h expected %02h at %0t", tag, got, exp, $time);
    end
  endtask

  // Behavioural reference model
  logic [7:0] m_drv = 0, m_dir = 0, m_sel = 0, m_pen = 0, m_rd = 0;
  logic [7:0] m_q1 = 0, m_q2 = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_drv = 0; m_dir = 0; m_sel = 0; m_pen = 0; m_rd = 0; m_q1 = 0; m_q2 = 0;
    end else begin
      m_rd = 0;
      if (bus_sel && !bus_wr && bus_size == 2'd0) begin
        if      (bus_addr == 0) m_rd = m_q2;
        else if (bus_addr == 1) m_rd = m_drv;
        else if (bus_addr == 2) m_rd = m_dir;
        else if (bus_addr == 3) m_rd = m_sel;
        else if (bus_addr == 4) m_rd = m_pen;
      end
      if (bus_sel && bus_wr && bus_size == 2'd0) begin
        if      (bus_addr == 1) m_drv = bus_wdata;
        else if (bus_addr == 2) m_dir = bus_wdata;
        else if (bus_addr == 3) m_sel = bus_wdata;
        else if (bus_addr == 4) m_pen = bus_wdata;
      end
      m_q2 = m_q1;
      m_q1 = pin_in;
    end
    #5;
    if (rst_n) begin
      logic [7:0] e_oe, e_out;
      e_oe  = (m_sel & alt_oe) | (~m_sel & m_dir);
      e_out = (m_sel & alt_out) | (~m_sel & m_dir & m_drv);
      chk("R9 model rdata", bus_rdata, m_rd);
      chk("R2 model pad_oe", pad_oe, e_oe);
      chk("R3 model pad_out", pad_out, e_out);
      chk("R6 model pull_en", pull_en, m_pen & ~e_oe);
      chk("R6 model pull_up", pull_up, m_pen & ~e_oe & m_drv);
    end
  end

  task automatic wr(input logic [3:0] a, input logic [7:0] d, input logic [1:0] sz);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d; bus_size = sz;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0; bus_size = 0;
  endtask

  task automatic rd(input string tag, input logic [3:0] a, input logic [1:0] sz,
                    input logic [7:0] exp);
    @(negedge clk);
    bus_sel = 1; bus_wr = 0; bus_addr = a; bus_size = sz;
    @(posedge clk); #5;
    chk(tag, bus_rdata, exp);
    @(negedge clk);
    bus_sel = 0; bus_size = 0;
  endtask

  initial begin
    #(20 * 200000);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: got timeout expected finish");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(posedge clk); #5;
    chk("R1 reset pad_oe", pad_oe, 8'h00);
    chk("R1 reset pad_out", pad_out, 8'h00);
    chk("R1 reset pull_en", pull_en, 8'h00);
    rd("R1 reset dir", 4'h2, 2'd0, 8'h00);

    wr(4'h2, 8'hF0, 2'd0);
    wr(4'h1, 8'hAA, 2'd0);
    #1;
    chk("R2 dir drives oe", pad_oe, 8'hF0);
    chk("R3 output pins only", pad_out, 8'hA0);
    rd("R9 drive readback", 4'h1, 2'd0, 8'hAA);
    rd("R9 dir readback", 4'h2, 2'd0, 8'hF0);

    @(negedge clk); pin_in = 8'h5C;
    repeat (3) @(negedge clk);
    rd("R4 synced level", 4'h0, 2'd0, 8'h5C);
    @(negedge clk);
    pin_in = 8'h33; bus_sel = 1; bus_wr = 0; bus_addr = 4'h0; bus_size = 0;
    @(posedge clk); #5;
    chk("R4 fresh change hidden", bus_rdata, 8'h5C);
    @(negedge clk); bus_sel = 0;
    repeat (2) @(negedge clk);
    rd("R4 change visible", 4'h0, 2'd0, 8'h33);

    @(negedge clk); alt_out = 8'h05; alt_oe = 8'h03;
    wr(4'h3, 8'h0F, 2'd0);
    #1;
    chk("R5 alt oe", pad_oe, 8'hF3);
    chk("R5 alt out", pad_out, 8'hA5);
    rd("R9 fsel readback", 4'h3, 2'd0, 8'h0F);

    wr(4'h4, 8'hFF, 2'd0);
    #1;
    chk("R6 pull on undriven", pull_en, 8'h0C);
    chk("R6 pull direction", pull_up, 8'h08);
    rd("R9 pull readback", 4'h4, 2'd0, 8'hFF);

    wr(4'h2, 8'h00, 2'd2);
    wr(4'h1, 8'h00, 2'd1);
    #1;
    chk("R7 word write ignored", pad_oe, 8'hF3);
    chk("R7 half write ignored", pad_out, 8'hA5);
    rd("R7 half read zero", 4'h2, 2'd1, 8'h00);
    rd("R7 word read zero", 4'h1, 2'd2, 8'h00);

    rd("R8 unmapped read", 4'h7, 2'd0, 8'h00);
    rd("R8 top offset read", 4'hF, 2'd0, 8'h00);
    wr(4'h0, 8'hFF, 2'd0);
    #1;
    chk("R8 level write no effect", pad_out, 8'hA5);
    rd("R8 level after write", 4'h0, 2'd0, 8'h33);

    wr(4'h3, 8'h00, 2'd0);
    wr(4'h2, 8'h0F, 2'd0);
    #1;
    chk("R2 dir flipped", pad_oe, 8'h0F);
    chk("R3 new output set", pad_out, 8'h0A);
    chk("R6 pull follows direction", pull_en, 8'hF0);
    chk("R6 pull up bits", pull_up, 8'hA0);

    repeat (4) @(negedge clk);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule